// File: doc/BRIEF.md
# Serial Bitwise Logic Unit

This block keeps two operand registers, A and B, and combines them one bit position per clock. A 3-bit function code picks one of eight bitwise operations. When an execute request arrives, both registers shift right together for exactly as many clocks as they have bits. On each of those clocks the unit computes the result bit from the two least significant bits. A routing select then decides whether that bit enters the MSB of A, of B, of both, or of neither. When neither is selected, each register rotates its own LSB back in.

The eight operations come from a four-way selector over base operations, followed by an XOR stage. The XOR stage inverts the selected bit when the top code bit is set. The controller has two states. Its shift-enable output is combinational in the current state and the execute input, so shifting starts in the same cycle that execute is raised. A held execute produces only one run. Operands are loaded in parallel through a synchronous load input, which takes effect only while the unit is not shifting.

Top module: `serial_logic_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, both registers read zero, the shift output is 0 and the done output is 0.
- R2: With load_i high and shift_o low, a clock edge copies a_in_i into A and b_in_i into B. With both load_i and shift_o low, both registers keep their values.
- R3: load_i has no effect in any cycle where shift_o is high. The result of the run in progress is unchanged.
- R4: func_i[1:0] selects the base operation on each bit pair (a, b): 00 AND, 01 OR, 10 XOR, 11 constant 1. func_i[2] is 0 for these codes.
- R5: With func_i[2] = 1, the result bit is the complement of the base operation: NAND, NOR, XNOR and constant 0.
- R6: Each run asserts shift_o for exactly WIDTH consecutive clocks (4 by default). After the last of these, done_o goes high.
- R7: In the ready state (done_o low, idle), raising exec_i drives shift_o high in the same cycle, before any clock edge.
- R8: While exec_i stays high in the done state, done_o stays high and shift_o stays low. Dropping exec_i returns the unit to ready on the next edge, and a new exec_i then starts a new run.
- R9: route_i bit 0 sends the result to A and bit 1 sends it to B. A register that is not routed rotates its own bits. After a full run, a routed register holds f(A,B) and an unrouted one holds its original value.
- R10: If exec_i is dropped after the first shift clock, the run still completes all WIDTH shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Parallel load request |
| a_in_i | input | WIDTH | Parallel value for A |
| b_in_i | input | WIDTH | Parallel value for B |
| exec_i | input | 1 | Execute request (level) |
| func_i | input | 3 | Function code: bit 2 invert, bits 1:0 base operation |
| route_i | input | 2 | Result destination: bit 0 to A, bit 1 to B |
| a_o | output | WIDTH | Contents of register A |
| b_o | output | WIDTH | Contents of register B |
| shift_o | output | 1 | Mealy shift enable |
| done_o | output | 1 | High while in the done state |

## Verification
The bound checker watches the following on every cycle:
- the length of each shift burst and that it is followed by done;
- the combinational rise of shift_o on exec_i in the ready state;
- the done state holding while execute is held;
- parallel loading in idle cycles and register stability in other idle cycles.

The functional results can only be shown by the bench's scenarios. These cover all eight functions, the four routing choices, a load attempted during a run, and an execute dropped mid-run. The scoreboard compares them word by word against values computed from the function table.

// File: rtl/slu_pkg.sv
package slu_pkg;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_DONE  = 1'b1
    } slu_state_e;

    typedef struct packed {
        logic       invert;
        logic [1:0] base;
    } slu_func_t;

    localparam logic [1:0] OP_AND = 2'd0;
    localparam logic [1:0] OP_OR  = 2'd1;
    localparam logic [1:0] OP_XOR = 2'd2;
    localparam logic [1:0] OP_ONE = 2'd3;

    localparam int N_BASE = 4;

    function automatic logic [N_BASE-1:0] slu_candidates(input logic a, input logic b);
        logic [N_BASE-1:0] c;
        c[OP_AND] = a & b;
        c[OP_OR]  = a | b;
        c[OP_XOR] = a ^ b;
        c[OP_ONE] = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/slu_bitop.sv
module slu_bitop
    import slu_pkg::*;
(
    input  slu_func_t func,
    input  logic      a_bit,
    input  logic      b_bit,
    output logic      res_bit
);
    logic [N_BASE-1:0] cand;
    logic              picked;

    always_comb begin
        cand    = slu_candidates(a_bit, b_bit);
        picked  = cand[func.base];
        res_bit = picked ^ func.invert;
    end
endmodule

// File: rtl/slu_shreg.sv
module slu_shreg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift_en,
    input  logic             take_res,
    input  logic             res_bit,
    output logic [WIDTH-1:0] q
);
    logic fill_bit;

    always_comb fill_bit = take_res ? res_bit : q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {fill_bit, q[WIDTH-1:1]};
        end else if (load_en) begin
            q <= load_val;
        end
    end
endmodule

// File: rtl/slu_ctrl.sv
module slu_ctrl
    import slu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic exec_i,
    output logic shift_o,
    output logic done_o
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    slu_state_e    st;
    logic [CW-1:0] cnt;

    always_comb begin
        shift_o = !rst && (st == ST_READY) && (exec_i || (cnt != '0));
        done_o  = (st == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_READY;
            cnt <= '0;
        end else begin
            case (st)
                ST_READY: begin
                    if (shift_o) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) st <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (!exec_i) begin
                        st  <= ST_READY;
                        cnt <= '0;
                    end
                end
                default: st <= ST_READY;
            endcase
        end
    end
endmodule

// File: rtl/serial_logic_unit.sv
module serial_logic_unit
    import slu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] a_in_i,
    input  logic [WIDTH-1:0] b_in_i,
    input  logic             exec_i,
    input  logic [2:0]       func_i,
    input  logic [1:0]       route_i,
    output logic [WIDTH-1:0] a_o,
    output logic [WIDTH-1:0] b_o,
    output logic             shift_o,
    output logic             done_o
);
    localparam int N_REG = 2;

    logic                        shift_en;
    logic                        res_bit;
    logic                        load_ok;
    logic [N_REG-1:0][WIDTH-1:0] regs_q;
    logic [N_REG-1:0][WIDTH-1:0] load_vals;
    slu_func_t                   func;

    always_comb begin
        func         = slu_func_t'(func_i);
        load_ok      = load_i && !shift_en;
        load_vals[0] = a_in_i;
        load_vals[1] = b_in_i;
    end

    slu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .exec_i  (exec_i),
        .shift_o (shift_en),
        .done_o  (done_o)
    );

    slu_bitop u_bitop (
        .func    (func),
        .a_bit   (regs_q[0][0]),
        .b_bit   (regs_q[1][0]),
        .res_bit (res_bit)
    );

    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        slu_shreg #(.WIDTH(WIDTH)) u_reg (
            .clk      (clk),
            .rst      (rst),
            .load_en  (load_ok),
            .load_val (load_vals[g]),
            .shift_en (shift_en),
            .take_res (route_i[g]),
            .res_bit  (res_bit),
            .q        (regs_q[g])
        );
    end

    assign a_o     = regs_q[0];
    assign b_o     = regs_q[1];
    assign shift_o = shift_en;
endmodule

// File: rtl/slu_checker.sv
module slu_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             load_i,
    input logic [WIDTH-1:0] a_in_i,
    input logic [WIDTH-1:0] b_in_i,
    input logic             exec_i,
    input logic [WIDTH-1:0] a_o,
    input logic [WIDTH-1:0] b_o,
    input logic             shift_o,
    input logic             done_o
);
    localparam int RW = $clog2(WIDTH + 1) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)          run_q <= '0;
        else if (shift_o) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    // R6
    burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
        shift_o |-> (run_q < RW'(WIDTH)));

    // R6
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_o && $past(shift_o)) |-> (run_q == RW'(WIDTH) && done_o));

    // R7
    mealy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!done_o && exec_i) |-> shift_o);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && exec_i) |-> (!shift_o ##1 done_o));

    // R2
    idle_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !shift_o) |=> (a_o == $past(a_in_i) && b_o == $past(b_in_i)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !shift_o) |=> ($stable(a_o) && $stable(b_o)));

    // R1
    always @(negedge clk) begin
        if (rst) begin
            reset_state_chk: assert (!shift_o);
        end
    end
endmodule

bind serial_logic_unit slu_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .a_in_i  (a_in_i),
    .b_in_i  (b_in_i),
    .exec_i  (exec_i),
    .a_o     (a_o),
    .b_o     (b_o),
    .shift_o (shift_o),
    .done_o  (done_o)
);

// File: tb/tb_serial_logic_unit.sv
module tb_serial_logic_unit;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0;
    logic [W-1:0] a_in_i = '0;
    logic [W-1:0] b_in_i = '0;
    logic         exec_i = 1'b0;
    logic [2:0]   func_i = '0;
    logic [1:0]   route_i = '0;
    logic [W-1:0] a_o, b_o;
    logic         shift_o, done_o;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        string        req;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    serial_logic_unit #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .load_i(load_i), .a_in_i(a_in_i), .b_in_i(b_in_i),
        .exec_i(exec_i), .func_i(func_i), .route_i(route_i),
        .a_o(a_o), .b_o(b_o), .shift_o(shift_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [2:0] f, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        logic [W-1:0] r;
        case (f[1:0])
            2'b00:   r = a & b;
            2'b01:   r = a | b;
            2'b10:   r = a ^ b;
            default: r = '1;
        endcase
        return f[2] ? ~r : r;
    endfunction

    // monitor: compare when done rises
    logic done_prev = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (done_o && !done_prev) begin
                if (sb_q.size() == 0) begin
                    chk("R6 unexpected done", 32'(done_o), 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk({e.req, " A"}, 32'(a_o), 32'(e.a));
                    chk({e.req, " B"}, 32'(b_o), 32'(e.b));
                end
            end
            done_prev = done_o;
        end
    end

    task automatic load_ops(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        load_i = 1'b1; a_in_i = a; b_in_i = b;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // mode: 0 hold exec, 1 drop exec after first shift, 2 attempt load mid-run
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [2:0] f, input logic [1:0] rt,
                          input int mode, input string req);
        exp_t e;
        int   n;
        load_ops(a, b);
        e.a = rt[0] ? model(f, a, b) : a;
        e.b = rt[1] ? model(f, a, b) : b;
        e.req = req;
        sb_q.push_back(e);
        func_i = f; route_i = rt;
        exec_i = 1'b1;
        #1;
        chk("R7 mealy shift start", 32'(shift_o), 32'd1);
        n = 1;
        @(negedge clk);
        if (mode == 1) exec_i = 1'b0;
        if (mode == 2) begin load_i = 1'b1; a_in_i = ~a; b_in_i = ~b; end
        for (int i = 0; i < 2 * W && shift_o; i++) begin
            n++;
            @(negedge clk);
            load_i = 1'b0;
        end
        load_i = 1'b0;
        chk(mode == 1 ? "R10 shift count" : "R6 shift count", 32'(n), 32'(W));
        chk("R6 done after run", 32'(done_o), 32'd1);
        if (mode == 0) begin
            @(negedge clk);
            chk("R8 done held", 32'(done_o), 32'd1);
            chk("R8 no rerun", 32'(shift_o), 32'd0);
        end
        exec_i = 1'b0;
        @(negedge clk);
        chk("R8 back to ready", 32'(done_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset A", 32'(a_o), 32'd0);
        chk("R1 reset shift", 32'(shift_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 A after reset", 32'(a_o), 32'd0);
        chk("R1 B after reset", 32'(b_o), 32'd0);
        chk("R1 done after reset", 32'(done_o), 32'd0);

        load_ops(4'h9, 4'h6);
        chk("R2 load A", 32'(a_o), 32'h9);
        chk("R2 load B", 32'(b_o), 32'h6);
        repeat (2) @(negedge clk);
        chk("R2 idle hold A", 32'(a_o), 32'h9);

        for (int f = 0; f < 8; f++) begin
            run_op(4'hC, 4'hA, 3'(f), 2'b01, 0, f < 4 ? "R4 base op" : "R5 inverted op");
        end
        run_op(4'h5, 4'h3, 3'b000, 2'b10, 0, "R9 route B");
        run_op(4'h7, 4'hE, 3'b010, 2'b11, 0, "R9 route both");
        run_op(4'hB, 4'h4, 3'b001, 2'b00, 0, "R9 route none");
        run_op(4'h3, 4'hF, 3'b110, 2'b01, 1, "R10 early release");
        run_op(4'hA, 4'h6, 3'b101, 2'b11, 2, "R3 load ignored");

        repeat (2) @(negedge clk);
        chk("R6 scoreboard drained", 32'(sb_q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule